// File: doc/BRIEF.md
# Keyed-Enable Watchdog Reset Timer

This block is a recovery watchdog for an 8-bit controller system. It is clocked by the oscillator clock and advances once per machine cycle, as a one-cycle qualifier on `tick_i` marks it. After reset it is inert. Software arms it, or restarts it, by writing two key bytes in a fixed order to a service address on a simple register bus. Once it is armed, nothing on the bus can stop it. If software fails to restart it in time, the counter overflows, the watchdog disarms itself, and a reset output pulse of an exact number of oscillator clocks is driven. A separate pulse counter runs on the oscillator clock and sets the pulse width.

Two control inputs, normally taken from an auxiliary control register outside the block, shape this behaviour. One suppresses the reset-out pulse. The other stops counting while the CPU is idle. The counter also freezes while the system is in power-down. After a wake-up by interrupt, it stays frozen until the wake interrupt line returns high.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is disarmed and `wdt_rst_o` is low, and it stays low however long the clock runs with no key writes.
- R2: A write of 0x1E to bus address 0xA6, followed directly by a write of 0xE1 to address 0xA6, arms the watchdog and clears its count to zero. The same sequence on an armed watchdog restarts the count from zero.
- R3: A 0xE1 write to 0xA6 that does not follow directly on a 0x1E write to 0xA6 is ignored. Any write, at any address, between the two key bytes discards the first key.
- R4: While the watchdog is armed, no bus write other than a valid key pair changes its state or its time to overflow.
- R5: While armed, the count rises by one on each clock with `tick_i` high and is otherwise held. With the count cleared on the key-pair edge, the overflow edge is the 2^CNT_W-th counting edge after it.
- R6: On overflow `wdt_rst_o` rises after that edge and stays high for exactly PULSE_LEN (default 98) clock cycles. Overflow disarms the watchdog, so no further pulse comes until a new key pair is written.
- R7: With `rsto_dis_i` high, an overflow produces no pulse but still disarms the watchdog.
- R8: With `idle_pause_i` low, counting continues while `idle_i` is high. With `idle_pause_i` high, each clock with `idle_i` high is skipped and counting resumes when idle ends.
- R9: No clock with `pd_i` high advances the count. After `pd_i` falls, clocks with `wake_ni` low still do not count, and counting resumes on the first clock with `wake_ni` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| tick_i | input | 1 | Machine-cycle qualifier, high for one clock per machine cycle |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_addr_i | input | 8 | Register bus address |
| bus_wdata_i | input | 8 | Register bus write data |
| idle_i | input | 1 | CPU is in idle mode |
| idle_pause_i | input | 1 | Stop counting during idle when high |
| rsto_dis_i | input | 1 | Suppress the reset-out pulse when high |
| pd_i | input | 1 | Power-down: oscillator considered stopped |
| wake_ni | input | 1 | Wake interrupt line, active low |
| wdt_rst_o | output | 1 | Reset-out pulse |

## Verification
The assertions assume that every input is synchronous to `clk_i` and that no bus write occurs while `pd_i` is high, because the CPU cannot write with its clock stopped. They also assume that `rsto_dis_i` holds steady across an overflow. The bench drives every input on the falling edge. It holds the bus quiet during power-down and changes the control bits only between scenarios. A behavioural model follows each key write, pause window and power-down window, and predicts the exact clock on which the pulse rises and falls.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 8;
  localparam logic [7:0] SVC_ADDR = 8'hA6;
  localparam logic [7:0] KEY_ARM  = 8'h1E;
  localparam logic [7:0] KEY_FIRE = 8'hE1;

  typedef enum logic {
    KS_WAIT,
    KS_ARMED
  } key_state_e;
endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned      AW    = BUS_AW,
  parameter int unsigned      DW    = BUS_DW,
  parameter logic [AW-1:0]    ADDR  = SVC_ADDR,
  parameter logic [DW-1:0]    KEY_A = KEY_ARM,
  parameter logic [DW-1:0]    KEY_B = KEY_FIRE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          restart_o
);
  key_state_e state_q;
  logic hit_a, hit_b;

  assign hit_a = we_i && (addr_i == ADDR) && (wdata_i == KEY_A);
  assign hit_b = we_i && (addr_i == ADDR) && (wdata_i == KEY_B);

  // any write re-evaluates the sequence; only the first key leaves it armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= KS_WAIT;
    else if (we_i) state_q <= hit_a ? KS_ARMED : KS_WAIT;
  end

  assign restart_o = (state_q == KS_ARMED) && hit_b;

  // R3: second key only counts directly after a first-key write
  assert_key_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(we_i && (addr_i == ADDR) && (wdata_i == KEY_A)));
endmodule

// File: rtl/kwdt_gate.sv
module kwdt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic idle_i,
  input  logic idle_pause_i,
  input  logic pd_i,
  input  logic wake_ni,
  output logic count_en_o
);
  logic hold_q;

  // set through power-down, released once the wake line is back high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (pd_i)    hold_q <= 1'b1;
    else if (wake_ni) hold_q <= 1'b0;
  end

  assign count_en_o = tick_i && !pd_i && !(hold_q && !wake_ni)
                      && !(idle_i && idle_pause_i);

  assert_pd_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_i) && !wake_ni) |-> !count_en_o);
  assert_idle_pause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && idle_pause_i) |-> !count_en_o);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic count_en_i,
  output logic ovf_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = en_q && count_en_i && (&cnt_q) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (restart_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && count_en_i) begin
      if (&cnt_q) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_restart_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (en_q && cnt_q == '0));
  assert_no_sw_disable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !ovf_o) |=> en_q);
  assert_hold_when_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !restart_i) |=> $stable(cnt_q));
  assert_ovf_disarms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !en_q);
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int unsigned PULSE_LEN = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (start_i)         left_q <= PW'(PULSE_LEN);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  assert_pulse_starts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pulse_o);
  assert_pulse_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> !$past(start_i));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned PULSE_LEN = 98
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  input  logic              idle_i,
  input  logic              idle_pause_i,
  input  logic              rsto_dis_i,
  input  logic              pd_i,
  input  logic              wake_ni,
  output logic              wdt_rst_o
);
  logic restart_w, count_en_w, ovf_w, start_w;

  kwdt_unlock u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .restart_o (restart_w)
  );

  kwdt_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .idle_i       (idle_i),
    .idle_pause_i (idle_pause_i),
    .pd_i         (pd_i),
    .wake_ni      (wake_ni),
    .count_en_o   (count_en_w)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_w),
    .count_en_i (count_en_w),
    .ovf_o      (ovf_w)
  );

  assign start_w = ovf_w && !rsto_dis_i;

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .pulse_o (wdt_rst_o)
  );

  assert_suppress_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_w && rsto_dis_i && !wdt_rst_o) |=> !wdt_rst_o);
  assert_rise_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> !$past(rsto_dis_i));
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CW   = 12;
  localparam int PER  = 1 << CW;
  localparam int PLEN = 98;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, we = 1'b0, idle = 1'b0, pause = 1'b0, dis = 1'b0, pd = 1'b0, wake_n = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic rst_o;

  int tests = 0, fails = 0, cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  keyed_wdt #(.CNT_W(CW), .PULSE_LEN(PLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .idle_i(idle), .idle_pause_i(pause), .rsto_dis_i(dis),
    .pd_i(pd), .wake_ni(wake_n), .wdt_rst_o(rst_o)
  );

  // behavioural reference
  int m_cnt = 0, m_pulse = 0;
  bit m_en = 0, m_key1 = 0, m_hold = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pulse = 0; m_en = 0; m_key1 = 0; m_hold = 0;
    end else begin
      bit fire, adv;
      fire = we && addr == 8'hA6 && wdata == 8'hE1 && m_key1;
      adv  = m_en && tick && !pd && !(m_hold && !wake_n) && !(idle && pause);
      if (we) m_key1 = (addr == 8'hA6 && wdata == 8'h1E);
      if (pd) m_hold = 1; else if (wake_n) m_hold = 0;
      if (m_pulse > 0) m_pulse--;
      if (fire) begin
        m_en = 1; m_cnt = 0;
      end else if (adv) begin
        if (m_cnt == PER - 1) begin
          m_en = 0; m_cnt = 0;
          if (!dis) m_pulse = PLEN;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      tests++;
      if (rst_o !== (m_pulse != 0)) begin
        fails++;
        $display("FAIL %s cycle %0d: wdt_rst_o actual %0b expected %0b", phase, cycles, rst_o, m_pulse != 0);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog in %s: actual %0d cycles expected < 100000", phase, cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic unlock();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    int hi = 0;
    repeat (n) begin
      if (rst_o) hi++;
      @(negedge clk);
    end
    check(hi == 0, req, hi, 0);
  endtask

  // remaining cycles until rise, then pulse width
  task automatic expect_pulse(input int exp, input string req);
    int n = 0, len = 0;
    while (!rst_o && n < exp + 50) begin
      @(negedge clk); n++;
    end
    check(n == exp, req, n, exp);
    while (rst_o && len < PLEN + 50) begin
      @(negedge clk); len++;
    end
    check(len == PLEN, "R6 width", len, PLEN);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    phase = "R1";
    check(rst_o == 1'b0, "R1 reset level", rst_o, 0);
    quiet(PER + 200, "R1 no pulse unarmed");

    // R3: broken key sequences
    phase = "R3";
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E); wr(8'h8E, 8'hE1); wr(8'hA6, 8'hE1);
    quiet(PER + 200, "R3 bad sequences ignored");

    // R2 R5 R6: arm, exact overflow, width, self-disarm
    phase = "R5";
    unlock();
    expect_pulse(PER, "R5 overflow timing");
    phase = "R6";
    quiet(PER + 200, "R6 disarmed after overflow");

    // R4 + R2 restart
    phase = "R4";
    unlock();
    wait_n(1000);
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'h8E, 8'h01);
    expect_pulse(PER - 1003, "R4 stray writes no effect");
    phase = "R2";
    unlock();
    wait_n(2000);
    unlock();
    expect_pulse(PER, "R2 restart clears count");

    // R5: tick gating
    phase = "R5";
    unlock();
    wait_n(500);
    tick = 1'b0; wait_n(100); tick = 1'b1;
    expect_pulse(PER - 600 + 100, "R5 tick gating");

    // R7: suppressed pulse still disarms
    phase = "R7";
    dis = 1'b1;
    unlock();
    quiet(PER + 200, "R7 pulse suppressed");
    dis = 1'b0;
    quiet(PER + 200, "R7 disarmed after silent overflow");

    // R8: idle counting modes
    phase = "R8";
    unlock();
    wait_n(1000);
    idle = 1'b1; wait_n(500); idle = 1'b0;
    expect_pulse(PER - 1500, "R8 idle counts with pause off");
    pause = 1'b1;
    unlock();
    wait_n(1000);
    idle = 1'b1; wait_n(500); idle = 1'b0;
    expect_pulse(PER - 1000, "R8 idle pauses with pause on");
    pause = 1'b0;

    // R9: power-down and wake hold
    phase = "R9";
    unlock();
    wait_n(1000);
    pd = 1'b1; wait_n(300);
    pd = 1'b0; wake_n = 1'b0; wait_n(200);
    wake_n = 1'b1;
    expect_pulse(PER - 1000, "R9 frozen in power-down and wake hold");

    wait_n(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule